// File: doc/BRIEF.md
# Serial Channel Interrupt Request Arbiter

This block owns the two interrupt sources of one serial channel: a transmit request and a receive request. Each source has a small control register that holds a priority level and a request flag. The receive register also holds a select bit. That bit turns the receive request into an error request, and which errors count depends on whether the channel runs clock-synchronous or asynchronous. Event strobes from the serial core set the flags. Software can write them through a plain register-write port, and an acknowledge from the processor clears them.

The block checks both flags against the processor priority level and the global interrupt-disable flag. It then presents one registered interrupt-pending output and the source that wins. A source is eligible only when its level is strictly above the processor level. A higher level wins over a lower one, and on equal levels the receive source is presented. All pins are plain level or strobe controls with no handshake. Strobes count in any cycle in which they are high.

Top module: `sirq_arbiter`

## Requirements
- R1: After reset both request flags, both priority fields, the select bit, `irq_pend` and `irq_src` are 0.
- R2: A write (`wr_en`=1) goes to the transmit register when `wr_sel`=0 and to the receive register when `wr_sel`=1. It loads the priority from `wr_data[2:0]` and the request flag from `wr_data[3]`. For the receive register only, it also loads the error-select bit from `wr_data[5]`. A write can set a request flag or clear it.
- R3: A `tx_load` strobe sets the transmit request flag at the next clock edge.
- R4: With select bit 0, an `rx_load` strobe sets the receive request flag. The flag is left unchanged when `err_overrun` is high in the same cycle.
- R5: With select bit 1 and `sync_mode`=1, only `err_overrun` sets the receive flag. `rx_load`, `err_frame` and `err_parity` have no effect.
- R6: With select bit 1 and `sync_mode`=0, any of `err_overrun`, `err_frame` or `err_parity` sets the receive flag, and `rx_load` has no effect.
- R7: `ack` clears the flag named by `ack_src` (0 = transmit, 1 = receive). It takes priority over a hardware set and over a software write in the same cycle.
- R8: When a hardware set and a software write reach the same flag in one cycle, the flag ends at 1.
- R9: A source is eligible only if its flag is 1, its priority is strictly greater than `cpu_level`, and `irq_mask` is 0. Level 0 is therefore never eligible.
- R10: When both sources are eligible, `irq_src` names the one with the higher priority. On equal levels it names receive (1). It is 0 when nothing is pending.
- R11: `irq_pend` and `irq_src` are registered. They reflect flags, priorities, `cpu_level` and `irq_mask` as they stood at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_load | input | 1 | Transmit buffer moved to shift register |
| rx_load | input | 1 | Receive shift register moved to buffer |
| err_overrun | input | 1 | Overrun error strobe |
| err_frame | input | 1 | Framing error strobe |
| err_parity | input | 1 | Parity error strobe |
| sync_mode | input | 1 | 1 = clock-synchronous, 0 = asynchronous |
| wr_en | input | 1 | Control register write strobe |
| wr_sel | input | 1 | 0 = transmit register, 1 = receive register |
| wr_data | input | 8 | Write data |
| cpu_level | input | 3 | Processor priority level |
| irq_mask | input | 1 | Global interrupt disable |
| ack | input | 1 | Interrupt accepted strobe |
| ack_src | input | 1 | Source accepted, 0 = transmit, 1 = receive |
| tx_req | output | 1 | Transmit request flag |
| rx_req | output | 1 | Receive request flag |
| irq_pend | output | 1 | Registered interrupt pending |
| irq_src | output | 1 | Registered winning source, 0 = transmit, 1 = receive |

## Verification
The bench builds the block with its default parameters: a 3-bit priority, an 8-bit control word, the request flag at bit 3 and the select bit at bit 5. With these values the lowest level, a mid level and the strict-compare edge (priority equal to `cpu_level`) can all be reached with few writes. Every error source can be driven under both mode settings. The collisions of acknowledge, hardware set and software write in one cycle are forced directly. The one-cycle lag of the pending output is sampled on both sides of the edge.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  localparam int PRIO_W  = 3;
  localparam int CTRL_W  = 8;
  localparam int REQ_POS = 3;
  localparam int SEL_POS = 5;
  localparam int NUM_SRC = 2;

  typedef enum logic {
    SRC_TX = 1'b0,
    SRC_RX = 1'b1
  } src_e;
endpackage

// File: rtl/sirq_ctrl_reg.sv
module sirq_ctrl_reg #(
  parameter int PRIO_W  = sirq_pkg::PRIO_W,
  parameter int CTRL_W  = sirq_pkg::CTRL_W,
  parameter int REQ_POS = sirq_pkg::REQ_POS,
  parameter int SEL_POS = sirq_pkg::SEL_POS,
  parameter bit HAS_SEL = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              hw_set,
  input  logic              ack_hit,
  output logic [PRIO_W-1:0] prio,
  output logic              req,
  output logic              sel
);
  logic [PRIO_W-1:0] prio_q;
  logic              req_q;
  logic              req_d;
  logic              unused_data;

  assign unused_data = ^wr_data;

  // Clear by acknowledge first, then a hardware set, then software.
  always_comb begin
    req_d = req_q;
    if (ack_hit)      req_d = 1'b0;
    else if (hw_set)  req_d = 1'b1;
    else if (wr_hit)  req_d = wr_data[REQ_POS];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prio_q <= '0;
      req_q  <= 1'b0;
    end else begin
      req_q <= req_d;
      if (wr_hit) prio_q <= wr_data[PRIO_W-1:0];
    end
  end

  generate
    if (HAS_SEL) begin : g_sel
      logic sel_q;
      always_ff @(posedge clk) begin
        if (!rst_n)      sel_q <= 1'b0;
        else if (wr_hit) sel_q <= wr_data[SEL_POS];
      end
      assign sel = sel_q;
    end else begin : g_nosel
      assign sel = 1'b0;
    end
  endgenerate

  assign prio = prio_q;
  assign req  = req_q;

  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_hit |=> !req_q);
  assert_hw_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_set && !ack_hit) |=> req_q);
  assert_flag_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_set && !ack_hit && !wr_hit) |=> $stable(req_q));
  assert_prio_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(prio_q));
endmodule

// File: rtl/sirq_rx_event.sv
module sirq_rx_event (
  input  logic err_sel,
  input  logic sync_mode,
  input  logic rx_load,
  input  logic err_overrun,
  input  logic err_frame,
  input  logic err_parity,
  output logic set
);
  logic err_any;

  // Synchronous mode knows only overrun; asynchronous adds frame and parity.
  always_comb begin
    if (sync_mode) err_any = err_overrun;
    else           err_any = err_overrun | err_frame | err_parity;
  end

  always_comb begin
    if (err_sel) set = err_any;
    else         set = rx_load & ~err_overrun;
  end
endmodule

// File: rtl/sirq_pick.sv
module sirq_pick #(
  parameter int PRIO_W = sirq_pkg::PRIO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_req,
  input  logic [PRIO_W-1:0] tx_prio,
  input  logic              rx_req,
  input  logic [PRIO_W-1:0] rx_prio,
  input  logic [PRIO_W-1:0] cpu_level,
  input  logic              irq_mask,
  output logic              pend,
  output sirq_pkg::src_e    src
);
  import sirq_pkg::*;

  logic tx_ok, rx_ok;
  logic pend_d;
  src_e src_d;
  logic pend_q;
  src_e src_q;

  assign tx_ok = tx_req && (tx_prio > cpu_level) && !irq_mask;
  assign rx_ok = rx_req && (rx_prio > cpu_level) && !irq_mask;

  always_comb begin
    pend_d = tx_ok | rx_ok;
    src_d  = SRC_TX;
    if (rx_ok && (!tx_ok || rx_prio >= tx_prio)) src_d = SRC_RX;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      src_q  <= SRC_TX;
    end else begin
      pend_q <= pend_d;
      src_q  <= src_d;
    end
  end

  assign pend = pend_q;
  assign src  = src_q;

  assert_mask_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_mask |=> !pend_q);
  assert_tie_to_rx_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ok && rx_ok && tx_prio == rx_prio) |=> (src_q == SRC_RX));
  assert_idle_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q |-> (src_q == SRC_TX));
  assert_lag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_req && !rx_req) |=> !pend_q);
endmodule

// File: rtl/sirq_arbiter.sv
module sirq_arbiter #(
  parameter int PRIO_W  = sirq_pkg::PRIO_W,
  parameter int CTRL_W  = sirq_pkg::CTRL_W,
  parameter int REQ_POS = sirq_pkg::REQ_POS,
  parameter int SEL_POS = sirq_pkg::SEL_POS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_load,
  input  logic              rx_load,
  input  logic              err_overrun,
  input  logic              err_frame,
  input  logic              err_parity,
  input  logic              sync_mode,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic [PRIO_W-1:0] cpu_level,
  input  logic              irq_mask,
  input  logic              ack,
  input  logic              ack_src,
  output logic              tx_req,
  output logic              rx_req,
  output logic              irq_pend,
  output logic              irq_src
);
  import sirq_pkg::*;

  localparam int NSRC = NUM_SRC;

  logic [NSRC-1:0]   set_v, wr_v, ack_v, req_v, sel_v;
  logic [PRIO_W-1:0] prio_v [NSRC];
  logic              rx_set;
  src_e              src_w;
  logic              unused_tx_sel;

  sirq_rx_event u_rx_event (
    .err_sel     (sel_v[SRC_RX]),
    .sync_mode   (sync_mode),
    .rx_load     (rx_load),
    .err_overrun (err_overrun),
    .err_frame   (err_frame),
    .err_parity  (err_parity),
    .set         (rx_set)
  );

  assign set_v[SRC_TX] = tx_load;
  assign set_v[SRC_RX] = rx_set;

  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_src
      assign wr_v[g]  = wr_en && (wr_sel == 1'(g));
      assign ack_v[g] = ack && (ack_src == 1'(g));
      sirq_ctrl_reg #(
        .PRIO_W  (PRIO_W),
        .CTRL_W  (CTRL_W),
        .REQ_POS (REQ_POS),
        .SEL_POS (SEL_POS),
        .HAS_SEL (g == int'(SRC_RX))
      ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (wr_v[g]),
        .wr_data (wr_data),
        .hw_set  (set_v[g]),
        .ack_hit (ack_v[g]),
        .prio    (prio_v[g]),
        .req     (req_v[g]),
        .sel     (sel_v[g])
      );
    end
  endgenerate

  assign unused_tx_sel = sel_v[SRC_TX];

  sirq_pick #(.PRIO_W(PRIO_W)) u_pick (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_req    (req_v[SRC_TX]),
    .tx_prio   (prio_v[SRC_TX]),
    .rx_req    (req_v[SRC_RX]),
    .rx_prio   (prio_v[SRC_RX]),
    .cpu_level (cpu_level),
    .irq_mask  (irq_mask),
    .pend      (irq_pend),
    .src       (src_w)
  );

  assign irq_src = src_w;
  assign tx_req  = req_v[SRC_TX];
  assign rx_req  = req_v[SRC_RX];

  assert_overrun_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_v[SRC_RX] && rx_load && err_overrun && !wr_v[SRC_RX] && !rx_req) |=> !rx_req);
  assert_sync_ignores_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_v[SRC_RX] && sync_mode && !err_overrun && !wr_v[SRC_RX] && !rx_req) |=> !rx_req);
  assert_async_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_v[SRC_RX] && !sync_mode && (err_frame || err_parity) && !ack_v[SRC_RX]) |=> rx_req);
  assert_tx_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load && !ack_v[SRC_TX]) |=> tx_req);
endmodule

// File: tb/sirq_arbiter_tb.sv
`timescale 1ns/1ps
module sirq_arbiter_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tx_load, rx_load, err_overrun, err_frame, err_parity, sync_mode;
  logic       wr_en, wr_sel;
  logic [7:0] wr_data;
  logic [2:0] cpu_level;
  logic       irq_mask, ack, ack_src;
  logic       tx_req, rx_req, irq_pend, irq_src;
  int         n_chk = 0;
  int         n_bad = 0;

  always #2 clk = ~clk;

  sirq_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .tx_load(tx_load), .rx_load(rx_load),
    .err_overrun(err_overrun), .err_frame(err_frame), .err_parity(err_parity),
    .sync_mode(sync_mode), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cpu_level(cpu_level), .irq_mask(irq_mask), .ack(ack), .ack_src(ack_src),
    .tx_req(tx_req), .rx_req(rx_req), .irq_pend(irq_pend), .irq_src(irq_src)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic sel, logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic do_ack(logic s);
    ack = 1'b1; ack_src = s;
    step();
    ack = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 tx_req", 8'(tx_req), 8'd0);
    chk("R1 rx_req", 8'(rx_req), 8'd0);
    chk("R1 irq_pend", 8'(irq_pend), 8'd0);
    chk("R1 irq_src", 8'(irq_src), 8'd0);
  endtask

  task automatic t_tx_set();
    wr(1'b0, 8'h05);
    tx_load = 1'b1; step(); tx_load = 1'b0;
    chk("R3 tx_req set", 8'(tx_req), 8'd1);
    chk("R11 pend lags flag", 8'(irq_pend), 8'd0);
    step();
    chk("R11 pend after edge", 8'(irq_pend), 8'd1);
    chk("R10 src tx", 8'(irq_src), 8'd0);
  endtask

  task automatic t_ack();
    do_ack(1'b0);
    chk("R7 ack clears tx", 8'(tx_req), 8'd0);
    step();
    chk("R11 pend drops", 8'(irq_pend), 8'd0);
  endtask

  task automatic t_rx_normal();
    wr(1'b1, 8'h03);
    rx_load = 1'b1; err_overrun = 1'b1; step(); rx_load = 1'b0; err_overrun = 1'b0;
    chk("R4 overrun holds rx", 8'(rx_req), 8'd0);
    rx_load = 1'b1; step(); rx_load = 1'b0;
    chk("R4 rx_load sets", 8'(rx_req), 8'd1);
    step();
    chk("R9 rx eligible", 8'(irq_pend), 8'd1);
    chk("R10 src rx", 8'(irq_src), 8'd1);
  endtask

  task automatic t_arb();
    tx_load = 1'b1; step(); tx_load = 1'b0;
    step();
    chk("R10 higher tx wins", 8'(irq_src), 8'd0);
    wr(1'b1, 8'h0D);
    step();
    chk("R10 tie goes rx", 8'(irq_src), 8'd1);
  endtask

  task automatic t_elig();
    irq_mask = 1'b1; step();
    chk("R9 mask blocks", 8'(irq_pend), 8'd0);
    irq_mask = 1'b0; cpu_level = 3'd5; step();
    chk("R9 equal level blocked", 8'(irq_pend), 8'd0);
    cpu_level = 3'd4; step();
    chk("R9 above level passes", 8'(irq_pend), 8'd1);
  endtask

  task automatic t_ack_pri();
    ack = 1'b1; ack_src = 1'b1; rx_load = 1'b1;
    wr_en = 1'b1; wr_sel = 1'b1; wr_data = 8'h0D;
    step();
    ack = 1'b0; rx_load = 1'b0; wr_en = 1'b0;
    chk("R7 ack beats set and write", 8'(rx_req), 8'd0);
    chk("R7 other flag kept", 8'(tx_req), 8'd1);
  endtask

  task automatic t_hw_sw();
    wr(1'b0, 8'h05);
    chk("R2 sw clear", 8'(tx_req), 8'd0);
    tx_load = 1'b1; wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'h05;
    step();
    tx_load = 1'b0; wr_en = 1'b0;
    chk("R8 hw set beats sw clear", 8'(tx_req), 8'd1);
    wr(1'b1, 8'h0B);
    chk("R2 sw set", 8'(rx_req), 8'd1);
    wr(1'b1, 8'h03);
    chk("R2 sw clear rx", 8'(rx_req), 8'd0);
    do_ack(1'b0);
  endtask

  task automatic t_sync_err();
    wr(1'b1, 8'h23);
    sync_mode = 1'b1;
    rx_load = 1'b1; step(); rx_load = 1'b0;
    chk("R5 rx_load ignored", 8'(rx_req), 8'd0);
    err_frame = 1'b1; step(); err_frame = 1'b0;
    chk("R5 frame ignored", 8'(rx_req), 8'd0);
    err_parity = 1'b1; step(); err_parity = 1'b0;
    chk("R5 parity ignored", 8'(rx_req), 8'd0);
    err_overrun = 1'b1; step(); err_overrun = 1'b0;
    chk("R5 overrun sets", 8'(rx_req), 8'd1);
    wr(1'b1, 8'h23);
  endtask

  task automatic t_async_err();
    sync_mode = 1'b0;
    err_parity = 1'b1; step(); err_parity = 1'b0;
    chk("R6 parity sets", 8'(rx_req), 8'd1);
    wr(1'b1, 8'h23);
    err_frame = 1'b1; step(); err_frame = 1'b0;
    chk("R6 frame sets", 8'(rx_req), 8'd1);
    wr(1'b1, 8'h23);
    rx_load = 1'b1; step(); rx_load = 1'b0;
    chk("R6 rx_load ignored", 8'(rx_req), 8'd0);
    err_overrun = 1'b1; step(); err_overrun = 1'b0;
    chk("R6 overrun sets", 8'(rx_req), 8'd1);
    wr(1'b1, 8'h23);
  endtask

  task automatic t_level0();
    cpu_level = 3'd0;
    wr(1'b0, 8'h08);
    chk("R2 req bit written", 8'(tx_req), 8'd1);
    step();
    chk("R9 level zero blocked", 8'(irq_pend), 8'd0);
    wr(1'b0, 8'h09);
    step();
    chk("R9 level one passes", 8'(irq_pend), 8'd1);
    chk("R10 src tx alone", 8'(irq_src), 8'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    {tx_load, rx_load, err_overrun, err_frame, err_parity, sync_mode} = '0;
    {wr_en, wr_sel, irq_mask, ack, ack_src} = '0;
    wr_data = '0;
    cpu_level = 3'd2;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_tx_set();
    t_ack();
    t_rx_normal();
    t_arb();
    t_elig();
    t_ack_pri();
    t_hw_sw();
    t_sync_err();
    t_async_err();
    t_level0();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule